// File: doc/BRIEF.md
# Prescaled Reload Timer with Toggle Output

This block is a down-counting interval timer. It provides the fixed time base for a table-driven PWM, where every expiry of the timer advances a pattern table by one step. The peripheral clock first passes through a power-of-two prescaler, which is picked by a 3-bit select code. The counter then runs from a software-written reload value down to zero. When it passes zero it reloads and keeps running. The expiry period is therefore (reload + 1) × prescale clocks. To reach a target PWM rate, software sets the reload value to clk / (prescale × steps × f_pwm) − 1.

Each expiry does three things. It sets a sticky flag. It raises an interrupt request, provided the request is enabled. It flips a toggle output, so that output runs at half the expiry rate. The flag can be cleared in two ways. The CPU can write a zero to the flag bit. A DMA engine that services the request can also clear it with an acknowledge strobe, which lets the table transfers proceed without CPU involvement. Counting begins only after software sets the enable bit and then writes the self-clearing start bit.

The register port is a simple single-cycle write interface. Reads are combinational. Address 0 is the control word, address 1 is the reload value and address 2 is the live count, which is read-only.

Top module: `reload_tick_timer`

## Requirements
- R1: After reset the control word, the reload value and the count all read 0, and `irq` and `tout` are both 0.
- R2: Control bits [7:5] hold the prescale select code. Codes 4, 0, 5, 1, 6 and 2 divide by 2, 4, 8, 16, 32 and 64 respectively. The reserved codes 3 and 7 divide by 2.
- R3: Writing control bit 1 (start) with control bit 0 (enable) also set restarts the prescaler. The counter loads the reload value on the next prescaled tick, which falls P clocks after the write edge. It then decrements once per tick. The first expiry is therefore at edge (R + 2) × P after the write edge.
- R4: On each expiry the counter reloads from the reload register and keeps running. Later expiries are spaced exactly (R + 1) × P clocks apart.
- R5: The start bit always reads back as 0. A start write whose enable bit is 0 is ignored, and the count does not change.
- R6: Each expiry sets the flag (control bit 3). The `irq` output equals the flag ANDed with the interrupt enable (control bit 2).
- R7: A control write with bit 3 = 0 clears the flag. A control write with bit 3 = 1 leaves the flag unchanged.
- R8: A `dma_ack` pulse clears the flag. If an expiry occurs in the same cycle as the pulse, the expiry wins and the flag stays set.
- R9: The internal toggle flips on every expiry. `tout` shows the toggle while the output enable (control bit 4) is 1. While that bit is 0, `tout` is held at 0 but the toggle keeps advancing.
- R10: A reload value written while the counter runs is used first at the next expiry, so the period already in progress is unchanged. A read of address 2 returns the live count.
- R11: Clearing the enable bit stops counting at once. The count holds its value and no further expiries occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register address (0 control, 1 reload, 2 count) |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Combinational read data for `reg_addr` |
| dma_ack | input | 1 | Acknowledge strobe from a DMA engine, clears the flag |
| irq | output | 1 | Interrupt / DMA request |
| tout | output | 1 | Toggle output, flips on each expiry |

## Verification
The bench pushes the absolute cycle of every expected expiry into a queue, and a monitor compares each observed `tout` edge against that queue. Three kinds of timing error show up as early, late or missing edges:
- a prescaler that ignores the scrambled select mapping;
- a first period that skips the load tick;
- a reload write that cuts the running period short.

An acknowledge aimed exactly at an expiry edge exposes a design that lets the clear win and so drops a request. Start writes with enable low, and a toggle that stalls while the output is masked, are caught by reading the count back and by checking the parity of `tout` once the output is unmasked again.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

   localparam int unsigned ADDR_W  = 2;
   localparam int unsigned SEL_W   = 3;
   localparam int unsigned SHIFT_W = 3;

   // Control word bit positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_TRIG = 1;
   localparam int unsigned CB_IEN  = 2;
   localparam int unsigned CB_FLAG = 3;
   localparam int unsigned CB_OEN  = 4;
   localparam int unsigned CB_SEL  = 5;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL   = 2'd0,
      RA_RELOAD = 2'd1,
      RA_COUNT  = 2'd2
   } rtm_addr_e;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             oen;
      logic             ien;
      logic             en;
   } rtm_ctrl_t;

   // Maps the non-linear select code to log2 of the divide ratio.
   function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SEL_W-1:0] code);
      logic [SHIFT_W-1:0] sh;
      case (code)
         3'd4:    sh = 3'd1;
         3'd0:    sh = 3'd2;
         3'd5:    sh = 3'd3;
         3'd1:    sh = 3'd4;
         3'd6:    sh = 3'd5;
         3'd2:    sh = 3'd6;
         default: sh = 3'd1;
      endcase
      return sh;
   endfunction

endpackage

// File: rtl/rtm_prescaler.sv
module rtm_prescaler
   import rtm_pkg::*;
#(
   parameter int unsigned MAX_SHIFT = 6
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);

   localparam int unsigned NTAP = 2 ** SHIFT_W;

   logic [MAX_SHIFT-1:0] pcnt;
   logic [NTAP-1:0]      tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (!en)     pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
   end

   assign tap[0] = 1'b1;
   for (genvar s = 1; s < NTAP; s++) begin : g_tap
      if (s <= MAX_SHIFT) begin : g_real
         assign tap[s] = &pcnt[s-1:0];
      end else begin : g_clip
         assign tap[s] = &pcnt;
      end
   end

   assign tick = en & tap[shift];

endmodule

// File: rtl/rtm_down_counter.sv
module rtm_down_counter #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             trig,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             load_pend,
   output logic             uflow
);

   logic at_zero;
   assign at_zero = (count == '0);
   assign uflow   = en & tick & running & ~load_pend & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 load_pend <= 1'b0;
      else if (trig)              load_pend <= 1'b1;
      else if (!en)               load_pend <= 1'b0;
      else if (tick && load_pend) load_pend <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 running <= 1'b0;
      else if (!en)               running <= 1'b0;
      else if (tick && load_pend) running <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (en && tick) begin
         if (load_pend)    count <= reload_val;
         else if (running) count <= at_zero ? reload_val : count - 1'b1;
      end
   end

endmodule

// File: rtl/rtm_ctrl_regs.sv
module rtm_ctrl_regs
   import rtm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   input  logic              uflow,
   input  logic              dma_ack,
   input  logic [CNT_W-1:0]  count,
   output rtm_ctrl_t         ctrl,
   output logic              flag,
   output logic              trig,
   output logic [CNT_W-1:0]  reload,
   output logic [CNT_W-1:0]  rdata
);

   logic wr_ctrl, wr_reload;
   assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
   assign wr_reload = reg_wr && (reg_addr == RA_RELOAD);

   // A start request only counts when the same write leaves the timer enabled.
   assign trig = wr_ctrl && reg_wdata[CB_TRIG] && reg_wdata[CB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl.en  <= reg_wdata[CB_EN];
         ctrl.ien <= reg_wdata[CB_IEN];
         ctrl.oen <= reg_wdata[CB_OEN];
         ctrl.sel <= reg_wdata[CB_SEL +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload <= '0;
      else if (wr_reload) reload <= reg_wdata;
   end

   // Set has priority over both clear sources so no expiry is lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                flag <= 1'b0;
      else if (uflow)                            flag <= 1'b1;
      else if (dma_ack)                          flag <= 1'b0;
      else if (wr_ctrl && !reg_wdata[CB_FLAG])   flag <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            rdata[CB_EN]              = ctrl.en;
            rdata[CB_IEN]             = ctrl.ien;
            rdata[CB_FLAG]            = flag;
            rdata[CB_OEN]             = ctrl.oen;
            rdata[CB_SEL +: SEL_W]    = ctrl.sel;
         end
         RA_RELOAD: rdata = reload;
         RA_COUNT:  rdata = count;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/rtm_out_stage.sv
module rtm_out_stage #(
   parameter bit TOUT_IDLE = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic uflow,
   input  logic oen,
   input  logic ien,
   input  logic flag,
   output logic tog,
   output logic irq,
   output logic tout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tog <= 1'b0;
      else if (uflow) tog <= ~tog;
   end

   assign irq  = flag & ien;
   assign tout = oen ? tog : TOUT_IDLE;

endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
   import rtm_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned MAX_SHIFT = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              dma_ack,
   output logic              irq,
   output logic              tout
);

   localparam int unsigned CTRL_BITS = CB_SEL + SEL_W;

   if (CNT_W < CTRL_BITS || CNT_W > 32) begin : g_bad_width
      $error("reload_tick_timer: CNT_W must lie in 8..32");
   end
   if (MAX_SHIFT < 6) begin : g_bad_shift
      $error("reload_tick_timer: MAX_SHIFT must cover a divide by 64");
   end

   rtm_ctrl_t        ctrl;
   logic             flag, trig, tick, uflow, running, load_pend, tog;
   logic [CNT_W-1:0] reload, count;

   rtm_ctrl_regs #(.CNT_W(CNT_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .uflow(uflow), .dma_ack(dma_ack), .count(count),
      .ctrl(ctrl), .flag(flag), .trig(trig), .reload(reload), .rdata(reg_rdata)
   );

   rtm_prescaler #(.MAX_SHIFT(MAX_SHIFT)) i_pre (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .restart(trig),
      .shift(code_to_shift(ctrl.sel)), .tick(tick)
   );

   rtm_down_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .trig(trig), .tick(tick),
      .reload_val(reload), .count(count), .running(running),
      .load_pend(load_pend), .uflow(uflow)
   );

   rtm_out_stage #(.TOUT_IDLE(1'b0)) i_out (
      .clk(clk), .rst_n(rst_n), .uflow(uflow), .oen(ctrl.oen), .ien(ctrl.ien),
      .flag(flag), .tog(tog), .irq(irq), .tout(tout)
   );

endmodule

// File: rtl/rtm_checker.sv
module rtm_checker #(
   parameter int unsigned CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             ien,
   input logic             flag,
   input logic             tick,
   input logic             uflow,
   input logic             running,
   input logic             load_pend,
   input logic             tog,
   input logic             dma_ack,
   input logic             irq,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] reload
);

   assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && running && !load_pend && count != '0)
      |=> count == ($past(count) - {{(CNT_W-1){1'b0}}, 1'b1}));

   assert_reload_on_uflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> count == $past(reload));

   assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(uflow));

   assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ien));

   assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack && !uflow) |=> !flag);

   assert_uflow_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> flag);

   assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> tog != $past(tog));

   assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!running && $stable(count)));

endmodule

bind reload_tick_timer rtm_checker #(.CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl.en), .ien(ctrl.ien), .flag(flag),
   .tick(tick), .uflow(uflow), .running(running), .load_pend(load_pend),
   .tog(tog), .dma_ack(dma_ack), .irq(irq), .count(count), .reload(reload)
);

// File: tb/test_reload_tick_timer.sv
module test_reload_tick_timer;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [CW-1:0] reg_wdata = '0;
   logic [CW-1:0] reg_rdata;
   logic          dma_ack = 1'b0;
   logic          irq, tout;

   int  checks = 0;
   int  errors = 0;
   int  pc = 0;
   int  uf_total = 0;
   bit  mon_on = 1'b0;
   bit  done = 1'b0;
   logic tout_prev = 1'b0;
   int  exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) pc <= pc + 1;

   reload_tick_timer #(.CNT_W(CW)) i_reload_tick_timer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_ack(dma_ack),
      .irq(irq), .tout(tout)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, pc);
      end
   endtask

   function automatic logic [CW-1:0] cw(input bit en, input bit trg, input bit ien,
                                        input bit keep, input bit oen, input logic [2:0] sel);
      logic [CW-1:0] v;
      v = '0;
      v[0] = en; v[1] = trg; v[2] = ien; v[3] = keep; v[4] = oen; v[7:5] = sel;
      return v;
   endfunction

   // Scoreboard monitor: every tout edge must match the next expected cycle.
   always @(negedge clk) begin
      if (rst_n) begin
         if (tout !== tout_prev && mon_on) begin
            if (exp_q.size() == 0) begin
               chk("R4 unexpected toggle", pc, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk("R3/R4 expiry cycle", pc, e);
            end
         end
         tout_prev = tout;
      end
   end

   task automatic push(input int t);
      exp_q.push_back(t);
      uf_total++;
   endtask

   task automatic wr(input logic [1:0] a, input logic [CW-1:0] d, output int n);
      @(negedge clk);
      n = pc;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [CW-1:0] v, output int n);
      @(negedge clk);
      reg_addr = a;
      #1;
      v = reg_rdata;
      n = pc;
   endtask

   task automatic wait_until(input int t);
      while (pc < t) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int n, m, s, s2;
      logic [CW-1:0] v, v2;
      int codes[8]  = '{4, 0, 5, 1, 6, 2, 3, 7};
      int shifts[8] = '{1, 2, 3, 4, 5, 6, 1, 1};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tout_prev = tout;
      mon_on = 1'b1;

      // R1: reset state
      rd(2'd0, v, s); chk("R1 ctrl", v, 0);
      rd(2'd1, v, s); chk("R1 reload", v, 0);
      rd(2'd2, v, s); chk("R1 count", v, 0);
      chk("R1 irq", irq, 0);
      chk("R1 tout", tout, 0);

      // R3/R4/R6/R7: reload 7, divide by 2 (code 4)
      wr(2'd1, 16'd7, m);
      wr(2'd0, cw(1, 0, 1, 1, 1, 3'd4), m);
      wr(2'd0, cw(1, 1, 1, 1, 1, 3'd4), n);
      push(n + 19); push(n + 35); push(n + 51);
      wait_until(n + 20);
      chk("R6 irq after expiry", irq, 1);
      wr(2'd0, cw(1, 0, 1, 1, 1, 3'd4), m);
      chk("R7 write one keeps flag", irq, 1);
      wr(2'd0, cw(1, 0, 1, 0, 1, 3'd4), m);
      chk("R7 write zero clears flag", irq, 0);
      wait_until(n + 52);
      chk("R4 all expiries seen", exp_q.size(), 0);
      rd(2'd0, v, s);
      chk("R5 start bit reads 0", v[1], 0);
      wr(2'd0, cw(1, 0, 0, 1, 1, 3'd4), m);
      chk("R6 irq masked by ien", irq, 0);
      rd(2'd0, v, s);
      chk("R6 flag still set", v[3], 1);
      // R11: stop
      wr(2'd0, cw(0, 0, 0, 1, 1, 3'd4), m);
      rd(2'd2, v, s);
      repeat (40) @(negedge clk);
      rd(2'd2, v2, s);
      chk("R11 count holds", v2, v);
      // R5: start with enable low is ignored
      wr(2'd0, cw(0, 1, 0, 1, 1, 3'd4), m);
      repeat (40) @(negedge clk);
      rd(2'd2, v2, s);
      chk("R5 ignored start keeps count", v2, v);
      chk("R5 no expiry", exp_q.size(), 0);

      // R2: every select code, reload 1
      wr(2'd1, 16'd1, m);
      for (int i = 0; i < 8; i++) begin
         int p;
         p = 1 << shifts[i];
         wr(2'd0, cw(1, 0, 0, 0, 1, 3'(codes[i])), m);
         wr(2'd0, cw(1, 1, 0, 0, 1, 3'(codes[i])), n);
         push(n + 1 + 3 * p); push(n + 1 + 5 * p);
         wait_until(n + 2 + 5 * p);
         wr(2'd0, cw(0, 0, 0, 0, 1, 3'(codes[i])), m);
         chk($sformatf("R2 code %0d done", codes[i]), exp_q.size(), 0);
      end

      // R10: live count and reload change mid-period, reload 5 div 2
      wr(2'd1, 16'd5, m);
      wr(2'd0, cw(1, 1, 0, 0, 1, 3'd4), n);
      push(n + 15);
      wait_until(n + 6);
      rd(2'd2, v, s);
      chk("R10 live count", v, 5 - (s - (n + 3)) / 2);
      repeat (2) @(negedge clk);
      rd(2'd2, v, s2);
      chk("R10 live count later", v, 5 - (s2 - (n + 3)) / 2);
      wr(2'd1, 16'd1, m);
      push(n + 19); push(n + 23);
      wait_until(n + 24);
      wr(2'd0, cw(0, 0, 0, 0, 1, 3'd4), m);
      chk("R10 new period used after expiry", exp_q.size(), 0);

      // R8: DMA acknowledge, reload 3 div 2
      wr(2'd1, 16'd3, m);
      wr(2'd0, cw(1, 1, 1, 0, 1, 3'd4), n);
      push(n + 11); push(n + 19); push(n + 27);
      wait_until(n + 12);
      chk("R8 irq set", irq, 1);
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      chk("R8 ack clears flag", irq, 0);
      wait_until(n + 18);
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      chk("R8 expiry beats ack", irq, 1);
      wait_until(n + 28);
      wr(2'd0, cw(0, 0, 0, 0, 1, 3'd4), m);
      chk("R8 expiries seen", exp_q.size(), 0);

      // R9: output masked, toggle still advances
      mon_on = 1'b0;
      wr(2'd0, cw(1, 1, 1, 0, 0, 3'd4), n);
      uf_total += 2;
      wait_until(n + 12);
      chk("R9 irq while masked", irq, 1);
      chk("R9 tout held low", tout, 0);
      wait_until(n + 20);
      chk("R9 tout still low", tout, 0);
      wr(2'd0, cw(0, 0, 1, 1, 0, 3'd4), m);
      wr(2'd0, cw(0, 0, 1, 1, 1, 3'd4), m);
      chk("R9 toggle parity", tout, uf_total % 2);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule